// File: doc/BRIEF.md
# D-Channel Contention Arbiter

This block decides when a terminal on a shared point-to-multipoint line may start sending on the D channel. The terminal's own echo input carries the bit the network reflected back for each D-bit slot. While a packet is waiting, the arbiter counts how many echoed ones arrive in a row. When that run reaches a terminal count, it grants the channel by raising `tx_en`, and the HDLC framer starts the opening flag in that cycle. The terminal count is 8 or 9 for the high class and 10 or 11 for the low class. A user-selected class picks the pair, and an internal level picks the member of that pair.

While it sends, the arbiter compares every transmitted D bit with the echo for the same slot. On a mismatch it drops `tx_en` in that same cycle, pulses the collision interrupt and the FIFO-flush request, and goes back to counting from zero. A packet that ends well moves the internal level to the higher count of the class. The level comes back down only after the line has shown that higher count of idle ones while this terminal had nothing to send. The acknowledge status bit follows grants and releases, but it changes only on frame pulses.

The controller has four states:
- `ST_IDLE`: nothing pending, level low.
- `ST_COUNT`: counting echo ones.
- `ST_SEND`: channel held.
- `ST_RECOVER`: nothing pending, level high, watching for a run that restores the level.

The transitions are:
- IDLE→COUNT: a packet becomes pending.
- COUNT→SEND: grant.
- COUNT→IDLE or COUNT→RECOVER: the pending flag drops.
- SEND→COUNT, SEND→IDLE or SEND→RECOVER: a collision, or packet done (the target depends on the pending flag and the level).
- RECOVER→COUNT: a packet becomes pending.
- RECOVER→IDLE: the restoring run completes.

Top module: `dch_arbiter`

## Requirements
- R1: With a packet pending, `tx_en` stays low until the echo run reaches the terminal count. The terminal count is 8 (high class, low level), 9 (high class, high level), 10 (low class, low level) or 11 (low class, high level).
- R2: An echo zero in any slot clears the run, so a full terminal count of new ones is needed afterwards.
- R3: `class_low`=1 selects the 10/11 pair and `class_low`=0 selects the 8/9 pair, whatever the internal level. The level only picks within the pair.
- R4: `tx_en` rises in the cycle after the slot that completed the count. It stays high until packet done or a collision.
- R5: While sending, a slot whose `tx_dbit` differs from `echo_bit` drops `tx_en` in that same cycle. In that cycle `coll_irq` and `fifo_flush` are both high for one cycle.
- R6: After a collision the run restarts from zero. The internal level is unchanged.
- R7: While `pkt_pending` is low the run is held at zero and no grant occurs. Dropping `pkt_pending` discards a partial run.
- R8: A `pkt_done` pulse while sending (with no collision) sets the internal level high.
- R9: With nothing pending and the level high, a run of echo ones equal to the class's higher count (9 or 11) returns the level to low.
- R10: `dc_ack` goes to 1 at the first frame pulse strictly after a grant. A frame pulse in the grant cycle itself does not set it.
- R11: `dc_ack` goes to 0 at the first frame pulse strictly after a collision or a packet done. Between two frame pulses the most recent event (grant, or collision/done) decides.
- R12: A collision in the same cycle as `pkt_done` counts as a collision. The level is not raised.
- R13: After reset, `tx_en`, `coll_irq`, `fifo_flush` and `dc_ack` are 0, and the level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | 1 | One-cycle strobe marking a D-bit slot |
| echo_bit | input | 1 | Echoed bit for the current slot |
| tx_dbit | input | 1 | D bit this terminal sends in the current slot |
| frame_pulse | input | 1 | Frame boundary strobe |
| class_low | input | 1 | User class: 0 selects high priority (8/9), 1 selects low priority (10/11) |
| pkt_pending | input | 1 | A packet is waiting in the transmit FIFO |
| pkt_done | input | 1 | The framer finished the current packet |
| tx_en | output | 1 | D channel granted; the framer drives the line |
| coll_irq | output | 1 | One-cycle collision interrupt |
| fifo_flush | output | 1 | One-cycle request to discard the rest of the packet |
| dc_ack | output | 1 | D-channel acknowledge status |

## Verification
Two things can coincide in one cycle: a frame pulse can land on the grant slot or on the collision slot, and a collision can arrive in the same cycle as `pkt_done`. The bench drives both coincidences in directed form. Its random phase also lets frame pulses fall on any cycle while grants and collisions happen. A behavioural model in the bench, built from R10, R11 and R12, decides whether `dc_ack` may move and whether the level rises. Each cycle's `tx_en`, `coll_irq`, `fifo_flush` and `dc_ack` are compared against that model.

// File: rtl/dch_pkg.sv
package dch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_SEND    = 2'd2,
        ST_RECOVER = 2'd3
    } arb_state_e;

    localparam int RUN_MAIN  = 0;
    localparam int RUN_QUIET = 1;
    localparam int RUN_NUM   = 2;

endpackage

// File: rtl/dch_term_sel.sv
module dch_term_sel #(
    parameter int CNT_W   = 4,
    parameter int HI_BASE = 8,
    parameter int LO_BASE = 10
) (
    input  logic             class_low,
    input  logic             level_hi,
    output logic [CNT_W-1:0] term_cnt,
    output logic [CNT_W-1:0] term_upper
);
    localparam logic [CNT_W-1:0] BASE_H = CNT_W'(HI_BASE);
    localparam logic [CNT_W-1:0] BASE_L = CNT_W'(LO_BASE);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic [CNT_W-1:0] base;

    // The user class picks the pair first; the internal level only adds one.
    always_comb begin
        base       = class_low ? BASE_L : BASE_H;
        term_cnt   = level_hi ? (base + ONE) : base;
        term_upper = base + ONE;
    end
endmodule

// File: rtl/dch_run_cnt.sv
module dch_run_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             slot,
    input  logic             bit_in,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             reach
);
    logic [CNT_W:0]   inc;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        inc   = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        reach = !hold && slot && bit_in && (inc >= {1'b0, limit});
        if (hold || reach) begin
            cnt_nxt = '0;
        end else if (slot) begin
            if (!bit_in)       cnt_nxt = '0;
            else if (inc[CNT_W]) cnt_nxt = cnt;
            else               cnt_nxt = inc[CNT_W-1:0];
        end else begin
            cnt_nxt = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    // R7: a held counter is empty on the following cycle.
    assert_hold_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0))
        else $error("run counter not cleared while held");

    // R2: an echoed zero breaks the run.
    assert_zero_breaks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && !bit_in) |=> (cnt == '0))
        else $error("run counter survived an echo zero");

    // R1: an idle cycle leaves an active run untouched.
    assert_no_slot_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot && !hold) |=> $stable(cnt))
        else $error("run counter moved without a slot");
endmodule

// File: rtl/dch_ack_track.sv
module dch_ack_track (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_pulse,
    input  logic set_evt,
    input  logic clr_evt,
    output logic ack
);
    logic set_pend;
    logic clr_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_pend <= 1'b0;
            clr_pend <= 1'b0;
            ack      <= 1'b0;
        end else begin
            if (frame_pulse) begin
                if (clr_pend)      ack <= 1'b0;
                else if (set_pend) ack <= 1'b1;
            end
            if (set_evt) begin
                set_pend <= 1'b1;
                clr_pend <= 1'b0;
            end else if (clr_evt) begin
                set_pend <= 1'b0;
                clr_pend <= 1'b1;
            end else if (frame_pulse) begin
                set_pend <= 1'b0;
                clr_pend <= 1'b0;
            end
        end
    end

    // R10: the acknowledge rises only on a frame boundary.
    assert_ack_rise_on_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(frame_pulse))
        else $error("acknowledge rose off a frame pulse");

    // R11: the acknowledge falls only on a frame boundary.
    assert_ack_fall_on_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> $past(frame_pulse))
        else $error("acknowledge fell off a frame pulse");

    // R11: grant and release never coincide.
    assert_events_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_evt && clr_evt))
        else $error("grant and release in one cycle");
endmodule

// File: rtl/dch_arbiter.sv
module dch_arbiter
    import dch_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int HI_BASE = 8,
    parameter int LO_BASE = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_valid,
    input  logic echo_bit,
    input  logic tx_dbit,
    input  logic frame_pulse,
    input  logic class_low,
    input  logic pkt_pending,
    input  logic pkt_done,
    output logic tx_en,
    output logic coll_irq,
    output logic fifo_flush,
    output logic dc_ack
);
    localparam int TOP_COUNT = LO_BASE + 1;

    initial begin
        if (TOP_COUNT >= (1 << CNT_W)) $error("CNT_W too narrow for LO_BASE");
        if (HI_BASE >= LO_BASE)        $error("HI_BASE must be below LO_BASE");
    end

    arb_state_e       state;
    arb_state_e       state_nxt;
    logic             level_hi;
    logic             collide;
    logic             grant;
    logic             finish_ok;
    logic             release_evt;
    logic [CNT_W-1:0] term_cnt;
    logic [CNT_W-1:0] term_upper;

    logic [RUN_NUM-1:0] run_hold;
    logic [RUN_NUM-1:0] run_reach;
    logic [CNT_W-1:0]   run_limit [RUN_NUM];
    logic [CNT_W-1:0]   run_val   [RUN_NUM];

    dch_term_sel #(
        .CNT_W  (CNT_W),
        .HI_BASE(HI_BASE),
        .LO_BASE(LO_BASE)
    ) u_term (
        .class_low (class_low),
        .level_hi  (level_hi),
        .term_cnt  (term_cnt),
        .term_upper(term_upper)
    );

    // Main run counts towards a grant; quiet run restores the level.
    always_comb begin
        run_hold[RUN_MAIN]   = (state != ST_COUNT) || !pkt_pending;
        run_limit[RUN_MAIN]  = term_cnt;
        run_hold[RUN_QUIET]  = (state != ST_RECOVER) || pkt_pending;
        run_limit[RUN_QUIET] = term_upper;
    end

    for (genvar g = 0; g < RUN_NUM; g++) begin : g_run
        dch_run_cnt #(.CNT_W(CNT_W)) u_run (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (run_hold[g]),
            .slot  (slot_valid),
            .bit_in(echo_bit),
            .limit (run_limit[g]),
            .cnt   (run_val[g]),
            .reach (run_reach[g])
        );
    end

    // Output process: Mealy decode of the present state and slot.
    always_comb begin
        collide     = (state == ST_SEND) && slot_valid && (tx_dbit != echo_bit);
        finish_ok   = (state == ST_SEND) && pkt_done && !collide;
        grant       = (state == ST_COUNT) && run_reach[RUN_MAIN];
        release_evt = collide || finish_ok;
        tx_en       = (state == ST_SEND) && !collide;
        coll_irq    = collide;
        fifo_flush  = collide;
    end

    // Next-state decode.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (pkt_pending) state_nxt = ST_COUNT;
            end
            ST_COUNT: begin
                if (!pkt_pending)  state_nxt = level_hi ? ST_RECOVER : ST_IDLE;
                else if (grant)    state_nxt = ST_SEND;
            end
            ST_SEND: begin
                if (collide) begin
                    if (pkt_pending)   state_nxt = ST_COUNT;
                    else if (level_hi) state_nxt = ST_RECOVER;
                    else               state_nxt = ST_IDLE;
                end else if (finish_ok) begin
                    state_nxt = pkt_pending ? ST_COUNT : ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (pkt_pending)                 state_nxt = ST_COUNT;
                else if (run_reach[RUN_QUIET])   state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Internal priority level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_hi <= 1'b0;
        end else if (finish_ok) begin
            level_hi <= 1'b1;
        end else if ((state == ST_RECOVER) && run_reach[RUN_QUIET]) begin
            level_hi <= 1'b0;
        end
    end

    dch_ack_track u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_pulse(frame_pulse),
        .set_evt    (grant),
        .clr_evt    (release_evt),
        .ack        (dc_ack)
    );

    // R4: the grant follows an echoed one.
    assert_grant_after_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(slot_valid && echo_bit))
        else $error("grant without a completing echo one");

    // R4: a clean slot keeps the channel.
    assert_hold_channel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SEND) && !pkt_done && !(slot_valid && (tx_dbit != echo_bit)))
        |=> (state == ST_SEND))
        else $error("channel dropped without cause");

    // R5/R6: the channel is gone after a collision.
    assert_coll_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        coll_irq |=> !tx_en)
        else $error("still sending after collision");

    // R8/R12: the level rises only after a clean finish.
    assert_level_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_hi) |-> $past((state == ST_SEND) && pkt_done && !coll_irq))
        else $error("level rose without a clean finish");

    // R9: the level falls only while recovering.
    assert_level_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_hi) |-> $past(state == ST_RECOVER))
        else $error("level fell outside recovery");
endmodule

// File: tb/dch_arbiter_tb.sv
module dch_arbiter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_valid = 1'b0, echo_bit = 1'b0, tx_dbit = 1'b0;
    logic frame_pulse = 1'b0, class_low = 1'b0, pkt_pending = 1'b0, pkt_done = 1'b0;
    logic tx_en, coll_irq, fifo_flush, dc_ack;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    // Requirement-level model.
    int  m_st = 0;      // 0 idle, 1 count, 2 send, 3 recover
    int  m_run = 0, m_qrun = 0;
    bit  m_lvl = 1'b0, m_ack = 1'b0, m_setp = 1'b0, m_clrp = 1'b0;
    bit  pend = 1'b0, cls = 1'b0;

    always #10 clk = ~clk;

    dch_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .echo_bit(echo_bit),
        .tx_dbit(tx_dbit), .frame_pulse(frame_pulse), .class_low(class_low),
        .pkt_pending(pkt_pending), .pkt_done(pkt_done),
        .tx_en(tx_en), .coll_irq(coll_irq), .fifo_flush(fifo_flush), .dc_ack(dc_ack)
    );

    function automatic int exp_tc(bit c, bit l);
        return c ? (l ? 11 : 10) : (l ? 9 : 8);
    endfunction

    task automatic chk(input logic act, input bit exp, input string tag, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit sv, input bit e, input bit d, input bit fp, input bit dn,
                       input string tag);
        bit ecoll, etx, fin, grant;
        @(negedge clk);
        slot_valid = sv; echo_bit = e; tx_dbit = d; frame_pulse = fp;
        pkt_done = dn; pkt_pending = pend; class_low = cls;
        #2;
        ecoll = (m_st == 2) && sv && (d != e);
        etx   = (m_st == 2) && !ecoll;
        chk(tx_en, etx, tag, "tx_en");
        chk(coll_irq, ecoll, tag, "coll_irq");
        chk(fifo_flush, ecoll, tag, "fifo_flush");
        chk(dc_ack, m_ack, tag, "dc_ack");
        fin = (m_st == 2) && dn && !ecoll;
        grant = 1'b0;
        case (m_st)
            0: if (pend) m_st = 1;
            1: begin
                if (!pend) begin
                    m_run = 0; m_st = m_lvl ? 3 : 0; m_qrun = 0;
                end else if (sv) begin
                    if (!e) m_run = 0;
                    else if (m_run + 1 >= exp_tc(cls, m_lvl)) begin
                        m_run = 0; m_st = 2; grant = 1'b1;
                    end else m_run++;
                end
            end
            2: begin
                if (ecoll)    m_st = pend ? 1 : (m_lvl ? 3 : 0);
                else if (fin) begin m_lvl = 1'b1; m_st = pend ? 1 : 3; end
                m_run = 0; m_qrun = 0;
            end
            default: begin
                if (pend) begin m_st = 1; m_qrun = 0; end
                else if (sv) begin
                    if (!e) m_qrun = 0;
                    else if (m_qrun + 1 >= exp_tc(cls, 1'b1)) begin
                        m_qrun = 0; m_lvl = 1'b0; m_st = 0;
                    end else m_qrun++;
                end
            end
        endcase
        if (fp) begin
            if (m_clrp)      m_ack = 1'b0;
            else if (m_setp) m_ack = 1'b1;
        end
        if (grant)               begin m_setp = 1'b1; m_clrp = 1'b0; end
        else if (ecoll || fin)   begin m_setp = 1'b0; m_clrp = 1'b1; end
        else if (fp)             begin m_setp = 1'b0; m_clrp = 1'b0; end
    endtask

    task automatic ones(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1, 1, 1, 0, 0, tag);
            cyc(0, 0, 0, 0, 0, tag);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(tx_en, 1'b0, "R13", "tx_en"); chk(dc_ack, 1'b0, "R13", "dc_ack");
        chk(coll_irq, 1'b0, "R13", "coll_irq"); chk(fifo_flush, 1'b0, "R13", "fifo_flush");
        rst_n = 1'b1;
        // R7: no pending, long run of ones, no grant
        ones(12, "R7");
        pend = 1'b1;
        cyc(0, 0, 0, 0, 0, "R7");
        ones(5, "R1");
        pend = 1'b0; cyc(0, 0, 0, 0, 0, "R7");   // partial run discarded
        pend = 1'b1; cyc(0, 0, 0, 0, 0, "R7");
        ones(7, "R1");
        cyc(1, 0, 0, 0, 0, "R2");                // zero breaks the run
        ones(7, "R2");
        cyc(1, 1, 1, 1, 0, "R10");               // 8th one, frame pulse in grant cycle
        cyc(0, 0, 0, 0, 0, "R4");
        cyc(0, 0, 0, 1, 0, "R10");               // ack sets here
        cyc(0, 0, 0, 0, 0, "R10");
        cyc(1, 0, 0, 0, 0, "R4");                // clean slots while sending
        cyc(1, 1, 1, 0, 0, "R4");
        cyc(0, 0, 0, 0, 1, "R8");                // clean finish, level high
        cyc(0, 0, 0, 0, 0, "R8");
        ones(8, "R8");
        cyc(1, 1, 1, 0, 0, "R8");                // 9th one grants
        cyc(1, 1, 0, 1, 0, "R5");                // collision with a frame pulse
        cyc(0, 0, 0, 0, 0, "R5");
        cyc(0, 0, 0, 1, 0, "R11");               // ack clears here
        cyc(0, 0, 0, 0, 0, "R11");
        ones(8, "R6");
        cyc(1, 1, 1, 0, 0, "R6");                // regrant at 9
        cyc(1, 0, 1, 0, 1, "R12");               // collision and done together
        cyc(0, 0, 0, 0, 0, "R12");
        ones(8, "R12");                          // level still high: 9 needed
        cyc(1, 1, 1, 0, 0, "R12");
        pend = 1'b0;
        cyc(0, 0, 0, 0, 1, "R9");                // done, nothing pending: recover
        cls = 1'b1;
        ones(10, "R9");
        cyc(1, 1, 1, 0, 0, "R9");                // 11th one restores level
        pend = 1'b1;
        cyc(0, 0, 0, 0, 0, "R3");
        ones(9, "R3");
        cyc(1, 1, 1, 0, 0, "R3");                // low class grant at 10
        cyc(0, 0, 0, 1, 1, "R11");
        // Random phase
        for (int k = 0; k < 6000; k++) begin
            bit sv, e, d, fp, dn;
            if (($urandom % 40) == 0) pend = ~pend;
            if (($urandom % 300) == 0) cls = ~cls;
            sv = ($urandom % 2) == 0;
            e  = ($urandom % 8) != 0;
            d  = (($urandom % 25) == 0) ? ~e : e;
            fp = ($urandom % 20) == 0;
            dn = (m_st == 2) && (($urandom % 15) == 0);
            cyc(sv, e, d, fp, dn, (k % 2 == 0) ? "R5" : "R10");
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule